// File: doc/BRIEF.md
# Serial Register Access Port

This block is the target side of a four-wire serial link. A host controller uses it to read and write a small bank of 8-bit control registers. Every transaction is one 16-bit frame framed by an active-low select. The host shifts a command byte and then a data byte. In the same frame the block returns a status byte and then the contents of the addressed register. One slot of the bank is a reset-mask register. Its three low bits drive dedicated enable outputs for the supervision logic that sits around this block.

The serial clock, select and data input are brought into the core clock domain through a synchronizer chain and turned into edge events. The core clock must therefore run several times faster than the serial clock. The frame engine counts sampling edges and checks the parity of the command. It fetches the read data once the command byte is complete, and it holds the write until select returns high. A frame that does not contain exactly sixteen sampling edges leaves every register as it was.

Top module: `spi_regport`

## Requirements
- R1: After reset every register bit is 0, the serial output enable is 0, and all three mask outputs are 0.
- R2: While the synchronized select is low the serial output is driven (`miso_oe_o` = 1). While it is high the output enable is 0.
- R3: Serial output bits change only on rising serial-clock edges, most significant bit first. The first 8 bits are the `status_i` value captured when select fell.
- R4: Input bits are sampled on falling serial-clock edges, most significant bit first. The first byte is, in shift order: write flag (1 = write, 0 = read), address bits 4 down to 0, parity bit, one ignored bit. The second byte is the write data.
- R5: The parity bit makes the count of ones among the write flag, the five address bits and the parity bit odd. On a parity error the second returned byte is 0x00 and no register is written.
- R6: The second returned byte is the content of the addressed register before this frame's write. Addresses at or above NUM_REGS read as 0x00.
- R7: A write takes effect only after select rises, and only if exactly 16 falling edges occurred while select was low. Frames with 15, 17 or any other count change no register.
- R8: Address 6 is the reset-mask register. Data bit 2 drives `thr_test_o`, bit 1 drives `hv_rst_en_o` and bit 0 drives `ot_rst_en_o`. Bits 7 to 3 always read as 0.
- R9: A valid write to an address at or above NUM_REGS changes no register.
- R10: Serial-clock edges while select is high have no effect on registers or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low frame select |
| sck_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from host |
| status_i | input | 8 | Status byte returned in the first half of each frame |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| regs_o | output | NUM_REGS*8 | Flat view of the register bank, register 0 in the low byte |
| thr_test_o | output | 1 | Lowered temperature threshold for test |
| hv_rst_en_o | output | 1 | High-voltage reset enable |
| ot_rst_en_o | output | 1 | Overtemperature reset enable |

## Verification
The bench builds the block with its defaults: eight registers, the mask register at address 6 and a two-stage synchronizer. With these values the 5-bit address field reaches both implemented registers and the 24 unimplemented ones, so reads and writes at and beyond the bank limit are both exercised. The serial clock runs at one sixteenth of the core clock, which leaves margin after the synchronizer before the bench samples the returned bits. Random frames mix correct and flipped parity with lengths of 8, 15, 16, 17 and 24 edges. Directed frames cover the mask-bit masking, idle clocking and the output-enable timing.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int FRAME_BITS = 2 * BYTE_W;

  // Command byte in shift order: flag, address, parity, ignored bit.
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic              par;
    logic              pad;
  } cmd_t;

  // Odd parity over flag, address and parity bit.
  function automatic logic cmd_parity_ok(cmd_t c);
    return ^{c.wr, c.addr, c.par};
  endfunction

  function automatic logic addr_in_bank(logic [ADDR_W-1:0] a, int num_regs);
    return int'(a) < num_regs;
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int             STAGES  = 2,
  parameter int             WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] rx_q;
  logic [BYTE_W-1:0]     tx_q;
  logic                  miso_q;
  cmd_t                  cmd_q;
  cmd_t                  cmd_live;
  logic                  cmd_done_evt;
  logic                  frame_full;
  logic                  commit_evt;

  assign cmd_live     = cmd_t'({rx_q[BYTE_W-2:0], mosi});
  assign rd_addr      = cmd_live.addr;
  assign cmd_done_evt = !sel_n && sck_fall && (cnt_q == CNT_W'(BYTE_W - 1));
  assign frame_full   = (cnt_q == CNT_W'(FRAME_BITS));
  assign commit_evt   = sel_rise && frame_full && cmd_q.wr && cmd_parity_ok(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
      cmd_q   <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (sel_fall) begin
        cnt_q  <= '0;
        rx_q   <= '0;
        tx_q   <= status;
        miso_q <= 1'b0;
        cmd_q  <= '0;
      end else if (!sel_n) begin
        if (sck_fall) begin
          rx_q <= {rx_q[FRAME_BITS-2:0], mosi};
          if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
          if (cmd_done_evt) begin
            cmd_q <= cmd_live;
            tx_q  <= cmd_parity_ok(cmd_live) ? rd_data : '0;
          end
        end else if (sck_rise) begin
          miso_q <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (commit_evt) begin
        wr_stb  <= 1'b1;
        wr_addr <= cmd_q.addr;
        wr_data <= rx_q[BYTE_W-1:0];
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = !sel_n;

  // R3: the output bit moves only on a rising clock event or a new frame
  p_miso_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_q) |-> $past(sck_rise || sel_fall));

  // R7: a write strobe always follows a select rising event
  p_wr_after_sel_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sel_rise));

  // R10: clock edges while deselected leave the shift state alone
  p_idle_sck_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !sel_rise && !sel_fall && sck_fall) |=> $stable(rx_q) && $stable(cnt_q));

  // R5: a command byte with bad parity never yields a write
  p_parity_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done_evt && !cmd_parity_ok(cmd_live)) |=> !cmd_parity_ok(cmd_q));
endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int MASK_ADDR = 6,
  parameter int MASK_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_stb && (wr_addr == ADDR_W'(g));
    if (g == MASK_ADDR) begin : g_mask
      logic [MASK_BITS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data[MASK_BITS-1:0];
      end
      assign regs_flat[g*BYTE_W +: BYTE_W] = {{(BYTE_W-MASK_BITS){1'b0}}, q};
    end else begin : g_plain
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign regs_flat[g*BYTE_W +: BYTE_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_flat[i*BYTE_W +: BYTE_W];
  end

  // R7: without a write strobe the bank holds its value
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_flat));

  // R9: writes beyond the bank touch nothing
  p_unimpl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_in_bank(wr_addr, NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int MASK_ADDR   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n_i,
  input  logic                       sck_i,
  input  logic                       mosi_i,
  input  logic [BYTE_W-1:0]          status_i,
  output logic                       miso_o,
  output logic                       miso_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic                       thr_test_o,
  output logic                       hv_rst_en_o,
  output logic                       ot_rst_en_o
);
  localparam int MASK_BITS = 3;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic wr_stb;
  logic [BYTE_W-1:0] mask_byte;

  // bit 2: select, bit 1: clock, bit 0: data
  spi_regport_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n), .din({sel_n_i, sck_i, mosi_i}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

  spi_regport_frame frame_i (
    .clk(clk), .rst_n(rst_n),
    .sel_n(s_lvl[2]), .sel_fall(s_fall[2]), .sel_rise(s_rise[2]),
    .sck_rise(s_rise[1]), .sck_fall(s_fall[1]), .mosi(s_lvl[0]),
    .status(status_i), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(miso_o), .miso_oe(miso_oe_o));

  spi_regport_regfile #(.NUM_REGS(NUM_REGS), .MASK_ADDR(MASK_ADDR), .MASK_BITS(MASK_BITS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_o));

  assign mask_byte   = regs_o[MASK_ADDR*BYTE_W +: BYTE_W];
  assign thr_test_o  = mask_byte[2];
  assign hv_rst_en_o = mask_byte[1];
  assign ot_rst_en_o = mask_byte[0];

  // R2: the pad is released whenever the synchronized select is high
  p_oe_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_lvl[2]) |-> !miso_oe_o);
endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;
  localparam int NREG = 8;
  localparam int MADR = 6;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sck = 0, mosi = 0;
  logic [7:0] status = 0;
  logic miso, miso_oe, thr, hve, ote;
  logic [NREG*8-1:0] regs;
  int checks = 0, errors = 0;
  logic [7:0] model [NREG];

  always #4 clk = ~clk;

  spi_regport #(.NUM_REGS(NREG), .MASK_ADDR(MADR), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .mosi_i(mosi),
    .status_i(status), .miso_o(miso), .miso_oe_o(miso_oe), .regs_o(regs),
    .thr_test_o(thr), .hv_rst_en_o(hve), .ot_rst_en_o(ote));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic odd_par_bit(input logic wr, input logic [4:0] a);
    int n = int'(wr);
    for (int i = 0; i < 5; i++) n += int'(a[i]);
    return (n % 2 == 0);
  endfunction

  function automatic logic [7:0] exp_read(input logic [4:0] a, input bit par_good);
    if (!par_good || a >= 5'(NREG)) return 8'h00;
    return model[a];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [15:0] bits, input int nedges, output logic [15:0] got);
    got = '0;
    sel_n = 0;
    cyc(6);
    for (int i = 0; i < nedges; i++) begin
      sck = 1;
      mosi = (i < 16) ? bits[15-i] : 1'b0;
      cyc(HALF);
      if (i < 16) got[15-i] = miso;
      sck = 0;
      cyc(HALF);
    end
    cyc(4);
    sel_n = 1;
    cyc(8);
  endtask

  // drive one transaction and check the returned bytes against the model
  task automatic xfer(input logic wr, input logic [4:0] a, input logic [7:0] d,
                      input bit par_good, input int nedges, input logic [7:0] st);
    logic [15:0] got;
    logic p;
    logic [7:0] er;
    p = odd_par_bit(wr, a) ^ !par_good;
    er = exp_read(a, par_good);
    status = st;
    cyc(2);
    run_frame({wr, a, p, 1'b0, d}, nedges, got);
    if (nedges == 16) begin
      chk(got[15:8] == st, "R3", "status byte", got[15:8], st);
      if (!par_good) chk(got[7:0] == 8'h00, "R5", "read on bad parity", got[7:0], 0);
      else chk(got[7:0] == er, "R6", "read data", got[7:0], er);
    end
    if (nedges == 16 && par_good && wr && a < 5'(NREG))
      model[a] = (a == 5'(MADR)) ? (d & 8'h07) : d;
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == model[i], req, $sformatf("reg %0d", i), regs[i*8 +: 8], model[i]);
    chk({thr, hve, ote} == model[MADR][2:0], "R8", "mask outputs", {thr, hve, ote}, model[MADR][2:0]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] g;
    int unsigned seed;
    seed = $urandom(32'd4411);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    cyc(5);
    rst_n = 1;
    cyc(3);
    // R1: reset state
    chk(miso_oe == 1'b0, "R1", "oe after reset", miso_oe, 0);
    chk_bank("R1");

    // R2: output enable follows select
    sel_n = 0; cyc(5);
    chk(miso_oe == 1'b1, "R2", "oe while selected", miso_oe, 1);
    sel_n = 1; cyc(5);
    chk(miso_oe == 1'b0, "R2", "oe after deselect", miso_oe, 0);

    // R4 / R8: write mask register with all ones, only three bits stick
    xfer(1'b1, 5'd6, 8'hFF, 1, 16, 8'hA5);
    chk_bank("R8");
    xfer(1'b0, 5'd6, 8'h00, 1, 16, 8'h3C);
    // R4: plain write and readback
    xfer(1'b1, 5'd2, 8'h96, 1, 16, 8'h01);
    xfer(1'b0, 5'd2, 8'h00, 1, 16, 8'h80);
    chk_bank("R4");
    // R5: bad parity blocks write
    xfer(1'b1, 5'd2, 8'h11, 0, 16, 8'h55);
    chk_bank("R5");
    // R7: 15 and 17 edges discard the write
    xfer(1'b1, 5'd3, 8'h77, 1, 15, 8'h00);
    xfer(1'b1, 5'd3, 8'h78, 1, 17, 8'h00);
    chk_bank("R7");
    // R9 / R6: beyond the bank
    xfer(1'b1, 5'd31, 8'hEE, 1, 16, 8'h42);
    chk_bank("R9");
    xfer(1'b0, 5'd31, 8'h00, 1, 16, 8'h24);
    // R10: clock while deselected, then a normal frame
    for (int i = 0; i < 5; i++) begin
      mosi = i[0]; sck = 1; cyc(HALF); sck = 0; cyc(HALF);
    end
    chk_bank("R10");
    xfer(1'b1, 5'd0, 8'hC3, 1, 16, 8'h99);
    chk_bank("R10");

    // random mix
    for (int n = 0; n < 80; n++) begin
      int r;
      int len;
      r = $urandom_range(0, 9);
      len = (r < 6) ? 16 : (r == 6) ? 15 : (r == 7) ? 17 : (r == 8) ? 8 : 24;
      xfer(1'($urandom_range(0, 1)), 5'($urandom_range(0, 9)), 8'($urandom),
           $urandom_range(0, 5) != 0, len, 8'($urandom));
      if (n % 10 == 9) chk_bank("R7");
    end
    chk_bank("R6");
    g = '0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule